// File: doc/BRIEF.md
# Shadow-Tag Sharer Directory

This block is the coherence directory attached to one bank of a shared second-level cache. It keeps a mirror of every first-level tag array: one slot for each (cache, set, way) triple. The directory therefore always knows which first-level caches hold a copy of a 64-byte line and where each copy sits. When a first-level cache misses on a load, it reports the missing address together with the set and the way it is about to replace. The directory writes the line address into that slot and marks the slot valid, which overwrites whatever line the slot held before.

When any core stores to a line, the directory compares the line against all mirrored slots in parallel. Every valid slot that holds the line produces one invalidate message naming the cache, set and way, and the slot is cleared in the same cycle that its message enters an outbound queue. This applies to the storing cache too. Messages leave the queue in the order they entered it. New requests are held off while a store is being resolved, and they stay held off when the queue has no room.

Line addresses are spread over the banks at 64-byte granularity. A request whose bank-select bits do not name this bank is reported as an error and changes nothing. The state machine has three states. IDLE accepts requests. SEARCH moves one matching slot per cycle into the queue. WAIT_SPACE holds a pending match while the queue is full. The transitions are: IDLE to SEARCH on an in-bank store, SEARCH to SEARCH while matches remain and the queue has room, SEARCH to WAIT_SPACE when a match remains but the queue is full, WAIT_SPACE to SEARCH once a slot frees, and SEARCH to IDLE when no match is left.

Top module: `sharer_dir`

## Requirements
- R1: After reset, req_ready is 1, inv_valid is 0, bank_err is 0 and every mirrored slot is invalid, so a store produces no invalidate.
- R2: An accepted in-bank load miss writes line address addr[ADDR_W-1:6] into slot (req_cid, req_set, req_way) and marks it valid, replacing the previous occupant of that slot.
- R3: An accepted in-bank store produces exactly one invalidate for each valid slot holding the same line, across all caches including the requester, and carries that slot's cache ID, set and way.
- R4: The invalidates of one store are issued in ascending order of the concatenated index {cid, set, way}, and all invalidates leave in the order they were queued.
- R5: A slot that produced an invalidate is invalid afterwards, so a second store to the same line with no new miss in between produces none.
- R6: A request whose bits addr[6 +: BANK_BITS] differ from BANK_ID raises bank_err for exactly the one cycle after it is accepted, and changes no slot. An in-bank request leaves bank_err at 0.
- R7: Matching is at line granularity: addresses that differ only in bits [5:0] match the same slots.
- R8: From the cycle after an in-bank store is accepted, req_ready stays 0 until all of its matches have been queued. At most one invalidate is queued per cycle.
- R9: When the invalidate queue is full and matches remain, the search stalls with req_ready at 0, and no invalidate is lost.
- R10: While inv_valid is 1 and inv_ready is 0, inv_valid stays 1 and inv_cid, inv_set and inv_way hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_store | input | 1 | 1 = store lookup, 0 = load-miss fill |
| req_cid | input | CID_W | Requesting first-level cache |
| req_addr | input | ADDR_W | Byte address |
| req_set | input | SET_W | First-level set index of the miss |
| req_way | input | WAY_W | Replacement way of the miss |
| bank_err | output | 1 | Pulse: the last accepted request belonged to another bank |
| inv_valid | output | 1 | Invalidate message available |
| inv_ready | input | 1 | Consumer takes the message |
| inv_cid | output | CID_W | Target cache of the invalidate |
| inv_set | output | SET_W | Target set |
| inv_way | output | WAY_W | Target way |

## Verification
Random load misses and stores draw their lines from a small pool, so many caches, and sometimes both ways of one set, share a line. This separates a correct all-slot match from one that stops after the first hit or skips the requester. The byte offsets are random, which shows whether the full line address, and only the line address, is compared. Directed sequences refill a slot with a new line and then store to the old one, which exposes stale replacement, and they repeat a store, which exposes entries that were not cleared. A directed burst of six sharers against a held-off consumer fills the queue and tests the stall and the hold of the message. A closing sweep stores to every line the model still holds, so any difference between a mirrored array and its modelled first-level cache shows up as a missing or extra invalidate. Requests aimed at other banks are mixed in throughout, and their lack of effect shows in the invalidates that follow.

// File: rtl/sharer_dir_pkg.sv
package sharer_dir_pkg;
    localparam int LINE_OFS = 6;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SEARCH     = 2'd1,
        ST_WAIT_SPACE = 2'd2
    } dir_state_t;
endpackage

// File: rtl/shadow_tag_array.sv
module shadow_tag_array #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [TAG_W-1:0]   cmp_tag,
    output logic [ENTRIES-1:0] hit_vec
);
    logic [ENTRIES-1:0] vld;
    logic [TAG_W-1:0]   tag [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[e] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                vld[e] <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(e)) begin
                vld[e] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
                tag[e] <= wr_tag;
            end
        end

        assign hit_vec[e] = vld[e] && (tag[e] == cmp_tag);
    end

    // R2
    no_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));

    // R2
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld[$past(wr_idx)]);

    // R5
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !vld[$past(clr_idx)]);
endmodule

// File: rtl/first_hit.sv
module first_hit #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/inv_fifo.sv
module inv_fifo #(
    parameter int W      = 6,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/sharer_dir.sv
module sharer_dir
    import sharer_dir_pkg::*;
#(
    parameter int NUM_L1    = 4,
    parameter int L1_SETS   = 8,
    parameter int L1_WAYS   = 2,
    parameter int ADDR_W    = 32,
    parameter int BANK_BITS = 2,
    parameter int BANK_ID   = 1,
    parameter int INV_DEPTH = 4,
    localparam int CID_W    = $clog2(NUM_L1),
    localparam int SET_W    = $clog2(L1_SETS),
    localparam int WAY_W    = $clog2(L1_WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [CID_W-1:0]  req_cid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    output logic              bank_err,
    output logic              inv_valid,
    input  logic              inv_ready,
    output logic [CID_W-1:0]  inv_cid,
    output logic [SET_W-1:0]  inv_set,
    output logic [WAY_W-1:0]  inv_way
);
    localparam int TAG_W   = ADDR_W - LINE_OFS;
    localparam int ENTRIES = NUM_L1 * L1_SETS * L1_WAYS;
    localparam int IDX_W   = CID_W + SET_W + WAY_W;

    dir_state_t state, state_nx;

    logic [TAG_W-1:0]   req_line, search_line;
    logic               in_bank, accept, start_store, fill_en;
    logic [ENTRIES-1:0] hit_vec;
    logic               found;
    logic [IDX_W-1:0]   pick_idx;
    logic               push, clr;
    logic               q_empty, q_full;
    logic [IDX_W-1:0]   q_head;

    assign req_line    = req_addr[ADDR_W-1:LINE_OFS];
    assign in_bank     = (req_line[BANK_BITS-1:0] == BANK_ID[BANK_BITS-1:0]);
    assign accept      = req_valid && req_ready;
    assign start_store = accept && req_store && in_bank;
    assign fill_en     = accept && !req_store && in_bank;

    shadow_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_idx  ({req_cid, req_set, req_way}),
        .wr_tag  (req_line),
        .clr_en  (clr),
        .clr_idx (pick_idx),
        .cmp_tag (search_line),
        .hit_vec (hit_vec)
    );

    first_hit #(.N(ENTRIES)) u_pick (
        .vec   (hit_vec),
        .found (found),
        .idx   (pick_idx)
    );

    inv_fifo #(.W(IDX_W), .DEPTH(INV_DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (pick_idx),
        .pop       (inv_valid && inv_ready),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start_store) state_nx = ST_SEARCH;
            ST_SEARCH:     if (!found)      state_nx = ST_IDLE;
                           else if (q_full) state_nx = ST_WAIT_SPACE;
            ST_WAIT_SPACE: if (!q_full)     state_nx = ST_SEARCH;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push      = 1'b0;
        clr       = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_SEARCH:     begin
                               push = found && !q_full;
                               clr  = found && !q_full;
                           end
            ST_WAIT_SPACE: ;
            default:       ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (start_store) search_line <= req_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_err <= 1'b0;
        else        bank_err <= accept && !in_bank;
    end

    assign inv_valid = !q_empty;
    assign {inv_cid, inv_set, inv_way} = q_head;

    // R10
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable({inv_cid, inv_set, inv_way})));

    // R8
    store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_store |=> !req_ready);

    // R6
    bank_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_err |-> $past(req_valid && req_ready));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SPACE) |-> (!req_ready && inv_valid));
endmodule

// File: tb/sharer_dir_test.sv
`timescale 1ns/1ps
module sharer_dir_test;
    localparam int NL = 4, NS = 8, NW = 2, AW = 32, BB = 2, BID = 1, QD = 4;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_store = 0, inv_ready = 0;
    logic [1:0]  req_cid = 0;
    logic [31:0] req_addr = 0;
    logic [2:0]  req_set = 0;
    logic [0:0]  req_way = 0;
    logic        req_ready, bank_err, inv_valid;
    logic [1:0]  inv_cid;
    logic [2:0]  inv_set;
    logic [0:0]  inv_way;

    sharer_dir #(.NUM_L1(NL), .L1_SETS(NS), .L1_WAYS(NW), .ADDR_W(AW),
                 .BANK_BITS(BB), .BANK_ID(BID), .INV_DEPTH(QD)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_cid(req_cid), .req_addr(req_addr),
        .req_set(req_set), .req_way(req_way), .bank_err(bank_err),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_cid(inv_cid),
        .inv_set(inv_set), .inv_way(inv_way));

    always #4 clk = ~clk;

    int checks = 0, fails = 0, rcvd = 0;
    bit hold = 0;
    bit         mv [NL][NS][NW];
    logic [25:0] ml [NL][NS][NW];
    logic [5:0] expq [$];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    function automatic logic [31:0] mk_addr(int tsel, int setv, bit inb, int ofs);
        logic [25:0] line;
        int bank;
        bank = inb ? BID : (BID + 1 + ($urandom % 3)) % 4;
        line = 26'((tsel << 5) | (setv << 2) | bank);
        return {line, 6'(ofs)};
    endfunction

    // monitor: drives inv_ready, checks each handshake against the expected order
    initial begin
        forever begin
            @(negedge clk);
            inv_ready = hold ? 1'b0 : ($urandom % 4 != 0);
            #1;
            if (rst_n && inv_valid && inv_ready) begin
                logic [5:0] got, e;
                got = {inv_cid, inv_set, inv_way};
                rcvd++;
                if (expq.size() == 0) begin
                    chk(0, "R3 unexpected invalidate", int'(got), -1);
                end else begin
                    e = expq.pop_front();
                    // R4 order, R3 payload
                    chk(got == e, "R4 invalidate order/payload", int'(got), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    task automatic do_req(bit st, int cid, logic [31:0] addr, int setv, int way);
        bit inb;
        inb = (addr[7:6] == 2'(BID));
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_store = st; req_cid = 2'(cid); req_addr = addr;
        req_set = 3'(setv); req_way = 1'(way);
        @(negedge clk);
        req_valid = 0;
        // R6
        chk(bank_err == !inb, "R6 bank_err", int'(bank_err), int'(!inb));
        if (inb && st) chk(!req_ready, "R8 busy after store", int'(req_ready), 0);
    endtask

    task automatic load_miss(int cid, logic [31:0] addr, int setv, int way);
        if (addr[7:6] == 2'(BID)) begin
            mv[cid][setv][way] = 1;
            ml[cid][setv][way] = addr[31:6];
        end
        do_req(0, cid, addr, setv, way);
    endtask

    task automatic store(int cid, logic [31:0] addr);
        if (addr[7:6] == 2'(BID)) begin
            for (int c = 0; c < NL; c++)
                for (int s = 0; s < NS; s++)
                    for (int w = 0; w < NW; w++)
                        if (mv[c][s][w] && ml[c][s][w] == addr[31:6]) begin
                            expq.push_back({2'(c), 3'(s), 1'(w)});
                            mv[c][s][w] = 0;
                        end
        end
        do_req(1, cid, addr, 0, 0);
    endtask

    task automatic quiet();
        @(negedge clk);
        while (!req_ready || expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NL; c++)
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) mv[c][s][w] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
        chk(inv_valid == 0, "R1 inv_valid", int'(inv_valid), 0);
        chk(bank_err == 0, "R1 bank_err", int'(bank_err), 0);
        begin
            int r0;
            r0 = rcvd;
            store(2, mk_addr(1, 3, 1, 0));
            quiet();
            chk(rcvd == r0, "R1 empty after reset", rcvd - r0, 0);
        end

        // R2 replacement: slot refilled with B, store to A finds nothing
        begin
            int r0;
            load_miss(0, mk_addr(2, 3, 1, 5), 3, 1);
            load_miss(0, mk_addr(3, 3, 1, 9), 3, 1);
            r0 = rcvd;
            store(1, mk_addr(2, 3, 1, 0));
            quiet();
            chk(rcvd == r0, "R2 replaced slot", rcvd - r0, 0);
            // R7 different offset same line
            r0 = rcvd;
            store(0, mk_addr(3, 3, 1, 63));
            quiet();
            chk(rcvd == r0 + 1, "R7 line match", rcvd - r0, 1);
            // R5 repeat store: no more invalidates
            r0 = rcvd;
            store(0, mk_addr(3, 3, 1, 1));
            quiet();
            chk(rcvd == r0, "R5 cleared", rcvd - r0, 0);
        end

        // R6 out-of-bank fill is ignored
        begin
            int r0;
            logic [31:0] a;
            a = mk_addr(0, 4, 0, 0);
            do_req(0, 1, a, 4, 0);
            r0 = rcvd;
            store(1, {a[31:8], 2'(BID), 6'd0});
            quiet();
            chk(rcvd == r0, "R6 no fill from other bank", rcvd - r0, 0);
        end

        // R9 full queue stall with six sharers
        begin
            logic [31:0] a;
            int r0;
            a = mk_addr(1, 5, 1, 12);
            for (int c = 0; c < NL; c++) load_miss(c, a, 5, 0);
            load_miss(0, a, 5, 1);
            load_miss(1, a, 5, 1);
            hold = 1;
            r0 = rcvd;
            store(3, a);
            repeat (12) @(negedge clk);
            chk(req_ready == 0, "R9 stall", int'(req_ready), 0);
            chk(inv_valid == 1, "R10 held valid", int'(inv_valid), 1);
            chk({inv_cid, inv_set, inv_way} == 6'({2'd0, 3'd5, 1'b0}),
                "R10 held payload", int'({inv_cid, inv_set, inv_way}), 10);
            hold = 0;
            quiet();
            chk(rcvd == r0 + 6, "R9 none lost", rcvd - r0, 6);
        end

        // random mix
        for (int n = 0; n < 500; n++) begin
            int k, ts, sv;
            bit inb;
            k = $urandom % 10;
            ts = $urandom % 4;
            sv = $urandom % NS;
            inb = (k != 9);
            if (k < 6) load_miss($urandom % NL, mk_addr(ts, sv, inb, $urandom % 64), sv, $urandom % NW);
            else store($urandom % NL, mk_addr(ts, sv, inb, $urandom % 64));
        end
        quiet();

        // sweep: reveal every slot the model still holds (R2 mirror)
        for (int c = 0; c < NL; c++)
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++)
                    if (mv[c][s][w]) store($urandom % NL, {ml[c][s][w], 6'd0});
        quiet();
        chk(expq.size() == 0, "R3 all expected seen", expq.size(), 0);
        summary();
    end
endmodule